// File: doc/BRIEF.md
# Halfword and Signed-Byte Transfer Unit

This unit executes one family of 32-bit load/store instruction words: those that move unsigned halfwords, signed halfwords and signed bytes between a register file and memory. It accepts one instruction at a time through a valid/ready handshake. It tests the instruction's condition against the NZCV flags and rejects malformed encodings. It forms an 8-bit immediate offset from two split nibbles and computes the transfer address from a base register, using pre- or post-indexing. It then runs one memory transaction and returns the results to the register file.

Each executed instruction has an address phase and a data phase. In the address phase the unit reads Rn and Rd, computes the address, and raises a one-cycle memory request with byte enables. In the data phase it waits for the memory response. Completion is signalled in the cycle the response arrives, and any register writes happen in that same cycle. The unit can write the base register and the destination register in the same cycle, through two write ports.

Top module: `hsx_unit`

## Requirements
- R1: `instr_ready` is high while the unit is idle, including straight after reset. It stays low from the cycle after an instruction is accepted until the instruction completes, so only one instruction is ever in flight.
- R2: The immediate offset is the unsigned value {instr[11:8], instr[3:0]}. instr[23]=1 adds it to the base read from register instr[19:16]. instr[23]=0 subtracts it.
- R3: With instr[24]=1 (pre-index), the transfer address is the modified base. The modified base is written back to Rn only when instr[21]=1.
- R4: With instr[24]=0 (post-index), the transfer address is the unmodified base, and the modified base is always written back to Rn.
- R5: The encoding is illegal if instr[6:5]=00, or instr[24]=0 together with instr[21]=1, or instr[27:25]≠000, or instr[22]≠1, or instr[7]≠1, or instr[4]≠1. An illegal instruction completes in the cycle after acceptance with `done_o` and `illegal_o` high, no memory request and no register write. This holds whatever the condition.
- R6: The condition instr[31:28] is tested against `nzcv` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V). The codes 0 to 13 are EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE. Code 14 always passes and code 15 never passes. A failing instruction completes in the cycle after acceptance with no memory request and no register write.
- R7: instr[20]=0 is a store of register instr[15:12]. A halfword store (instr[5]=1) drives `mem_be` 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1, with Rd[15:0] on the selected lanes. A byte store (instr[6:5]=10) enables only lane address[1:0], carrying Rd[7:0].
- R8: instr[20]=1 is a load into register instr[15:12]. Code 01 zero-extends the addressed halfword. Code 11 sign-extends the addressed halfword. Code 10 sign-extends the addressed byte.
- R9: When a load's destination equals its base register and write-back applies, only the loaded value is written. The base write port stays low.
- R10: The memory request is a single-cycle pulse in the cycle after acceptance. Completion, together with any register writes, happens in the cycle in which `mem_rvalid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr_word | input | 32 | Instruction word |
| nzcv | input | 4 | Condition flags N,Z,C,V (bit 3 down to bit 0) |
| rf_rn_idx | output | 4 | Base register index (read and base write) |
| rf_rn_data | input | DATA_W | Base register value |
| rf_rd_idx | output | 4 | Data register index (read and destination write) |
| rf_rd_data | input | DATA_W | Data register value for stores |
| rf_base_we | output | 1 | Write modified base to Rn |
| rf_base_data | output | DATA_W | Modified base value |
| rf_dst_we | output | 1 | Write loaded value to Rd |
| rf_dst_data | output | DATA_W | Extended load value |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | 1 for a store |
| mem_addr | output | DATA_W | Transfer address |
| mem_be | output | DATA_W/8 | Byte lane enables |
| mem_wdata | output | DATA_W | Store data, replicated over the lanes |
| mem_rvalid | input | 1 | Memory response (load data or store acknowledge) |
| mem_rdata | input | DATA_W | Full read word |
| done_o | output | 1 | Instruction completes this cycle |
| illegal_o | output | 1 | Completed instruction had an illegal encoding |

## Verification
The hardest case to reach is a load whose base and destination are the same register while write-back applies. Two writes compete for one register in a single completion cycle. The stimulus reaches it with a post-indexed load and with a pre-indexed load with write-back, each naming the same register for Rn and Rd. The bench checks that only the loaded value arrives. The memory model also varies its response latency from one to three cycles, so completion is checked at several distances from the request.

// File: rtl/hsx_pkg.sv
// Package: shared types and the condition test for the halfword/signed transfer unit.
// Assumes 32-bit instruction words and 4-bit register indices fixed by the encoding.
package hsx_pkg;
    localparam int INSTR_W = 32;
    localparam int RIDX_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_WAIT = 2'd2
    } hsx_state_e;

    typedef enum logic [1:0] {
        XK_SWAP  = 2'b00,
        XK_UHALF = 2'b01,
        XK_SBYTE = 2'b10,
        XK_SHALF = 2'b11
    } hsx_kind_e;

    typedef struct packed {
        logic [3:0]        cond;
        logic              pre;
        logic              up;
        logic              wback;
        logic              load;
        logic [RIDX_W-1:0] rn;
        logic [RIDX_W-1:0] rd;
        hsx_kind_e         kind;
        logic [7:0]        off;
        logic              bad;
    } hsx_dec_t;

    // Evaluate one of the 16 condition codes; flags are {N,Z,C,V}.
    function automatic logic hsx_cond_ok(input logic [3:0] code, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (code)
            4'd0:    return z;
            4'd1:    return !z;
            4'd2:    return c;
            4'd3:    return !c;
            4'd4:    return n;
            4'd5:    return !n;
            4'd6:    return v;
            4'd7:    return !v;
            4'd8:    return c && !z;
            4'd9:    return !c || z;
            4'd10:   return n == v;
            4'd11:   return n != v;
            4'd12:   return !z && (n == v);
            4'd13:   return z || (n != v);
            4'd14:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/hsx_decode.sv
// Module: hsx_decode
// Splits the held instruction word into fields, assembles the split immediate
// and flags illegal encodings. Purely combinational; assumes a stable input word.
module hsx_decode
    import hsx_pkg::*;
(
    input  logic [INSTR_W-1:0] ir,
    input  logic [3:0]         nzcv,
    output hsx_dec_t           dec,
    output logic               cond_ok
);
    logic fixed_ok;

    // Field extraction and encoding legality.
    always_comb begin
        fixed_ok    = (ir[27:25] == 3'b000) && ir[22] && ir[7] && ir[4];
        dec.cond    = ir[31:28];
        dec.pre     = ir[24];
        dec.up      = ir[23];
        dec.wback   = ir[21];
        dec.load    = ir[20];
        dec.rn      = ir[19:16];
        dec.rd      = ir[15:12];
        dec.kind    = hsx_kind_e'(ir[6:5]);
        dec.off     = {ir[11:8], ir[3:0]};
        dec.bad     = !fixed_ok || (ir[6:5] == 2'b00) || (!ir[24] && ir[21]);
    end

    // Condition test against the live flags.
    always_comb cond_ok = hsx_cond_ok(ir[31:28], nzcv);
endmodule

// File: rtl/hsx_lane.sv
// Module: hsx_lane
// Maps a halfword or byte onto memory byte lanes for stores and extracts and
// extends it for loads. Assumes DATA_W = 32 (four lanes, address bits [1:0]).
module hsx_lane
    import hsx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chk_en,
    input  hsx_kind_e           kind,
    input  logic [1:0]          addr_lo,
    input  logic [DATA_W-1:0]   st_src,
    input  logic [DATA_W-1:0]   ld_word,
    output logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   ld_ext
);
    localparam int LANES = DATA_W / 8;

    logic       is_half;
    logic [7:0]  ld_byte;
    logic [15:0] ld_half;

    assign is_half = kind[0];

    // One enable and one data byte per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            be[i]            = is_half ? ((i / 2) == int'(addr_lo[1])) : (i == int'(addr_lo));
            wdata[i*8 +: 8]  = is_half ? st_src[(i % 2)*8 +: 8] : st_src[7:0];
        end
    end

    // Select the addressed item and extend it to the full width.
    always_comb begin
        ld_byte = ld_word[{addr_lo, 3'b000} +: 8];
        ld_half = ld_word[{addr_lo[1], 4'b0000} +: 16];
        case (kind)
            XK_UHALF: ld_ext = {{(DATA_W-16){1'b0}}, ld_half};
            XK_SHALF: ld_ext = {{(DATA_W-16){ld_half[15]}}, ld_half};
            default:  ld_ext = {{(DATA_W-8){ld_byte[7]}}, ld_byte};
        endcase
    end

    assert_byte_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && kind == XK_SBYTE) |-> $countones(be) == 1);
    assert_half_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && is_half) |-> (be == 4'b0011 || be == 4'b1100));
endmodule

// File: rtl/hsx_unit.sv
// Module: hsx_unit (top)
// Runs one halfword/signed-byte load or store per handshake: decode, condition
// test, address formation with pre/post indexing, one memory transaction and
// register write-back. Assumes the register file reads combinationally and that
// memory answers every request with exactly one mem_rvalid pulse, at least one
// cycle after the request.
module hsx_unit
    import hsx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    output logic                 instr_ready,
    input  logic [INSTR_W-1:0]   instr_word,
    input  logic [3:0]           nzcv,
    output logic [RIDX_W-1:0]    rf_rn_idx,
    input  logic [DATA_W-1:0]    rf_rn_data,
    output logic [RIDX_W-1:0]    rf_rd_idx,
    input  logic [DATA_W-1:0]    rf_rd_data,
    output logic                 rf_base_we,
    output logic [DATA_W-1:0]    rf_base_data,
    output logic                 rf_dst_we,
    output logic [DATA_W-1:0]    rf_dst_data,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [DATA_W-1:0]    mem_addr,
    output logic [DATA_W/8-1:0]  mem_be,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_rvalid,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 done_o,
    output logic                 illegal_o
);
    localparam int LANES = DATA_W / 8;

    hsx_state_e        st_q;
    logic [INSTR_W-1:0] ir_q;
    logic [DATA_W-1:0] base_nxt_q;
    logic [1:0]        alo_q;
    logic              wb_q;

    hsx_dec_t          dec;
    logic              cond_ok;
    logic              in_exec, go, finish;
    logic [DATA_W-1:0] off_ext, mod_base, xfer_addr;
    logic [1:0]        lane_sel;
    logic [DATA_W-1:0] ld_ext;

    hsx_decode u_dec (
        .ir      (ir_q),
        .nzcv    (nzcv),
        .dec     (dec),
        .cond_ok (cond_ok)
    );

    // Address arithmetic and phase control signals.
    always_comb begin
        in_exec   = (st_q == ST_EXEC);
        go        = in_exec && !dec.bad && cond_ok;
        finish    = (st_q == ST_WAIT) && mem_rvalid;
        off_ext   = {{(DATA_W-8){1'b0}}, dec.off};
        mod_base  = dec.up ? (rf_rn_data + off_ext) : (rf_rn_data - off_ext);
        xfer_addr = dec.pre ? mod_base : rf_rn_data;
        lane_sel  = in_exec ? xfer_addr[1:0] : alo_q;
    end

    hsx_lane #(.DATA_W(DATA_W)) u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .chk_en  (mem_req),
        .kind    (dec.kind),
        .addr_lo (lane_sel),
        .st_src  (rf_rd_data),
        .ld_word (mem_rdata),
        .be      (mem_be),
        .wdata   (mem_wdata),
        .ld_ext  (ld_ext)
    );

    // Sequencer: idle -> address phase -> wait for the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            ir_q       <= '0;
            base_nxt_q <= '0;
            alo_q      <= '0;
            wb_q       <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (instr_valid) begin
                    ir_q <= instr_word;
                    st_q <= ST_EXEC;
                end
                ST_EXEC: if (go) begin
                    base_nxt_q <= mod_base;
                    alo_q      <= xfer_addr[1:0];
                    wb_q       <= dec.pre ? dec.wback : 1'b1;
                    st_q       <= ST_WAIT;
                end else begin
                    st_q <= ST_IDLE;
                end
                ST_WAIT: if (mem_rvalid) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive: handshake, memory request, completion and register writes.
    always_comb begin
        instr_ready  = (st_q == ST_IDLE);
        rf_rn_idx    = dec.rn;
        rf_rd_idx    = dec.rd;
        mem_req      = go;
        mem_we       = !dec.load;
        mem_addr     = xfer_addr;
        done_o       = (in_exec && !go) || finish;
        illegal_o    = in_exec && dec.bad;
        rf_dst_we    = finish && dec.load;
        rf_dst_data  = ld_ext;
        rf_base_we   = finish && wb_q && !(dec.load && dec.rn == dec.rd);
        rf_base_data = base_nxt_q;
    end

    assert_exec_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready) |=> (mem_req || done_o));
    assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || done_o) |-> !instr_ready);
    assert_illegal_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (done_o && !mem_req && !rf_dst_we && !rf_base_we));
    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_base_we && rf_dst_we) |-> (rf_rn_idx != rf_rd_idx));
    assert_writes_on_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_base_we || rf_dst_we) |-> (mem_rvalid && done_o));
endmodule

// File: tb/tb_hsx_unit.sv
module tb_hsx_unit;
    localparam int CLK_PERIOD = 10;
    localparam int Q = CLK_PERIOD / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [31:0] instr_word = '0;
    logic [3:0]  nzcv = '0;
    logic [3:0]  rf_rn_idx, rf_rd_idx;
    logic [31:0] rf_rn_data, rf_rd_data;
    logic        rf_base_we, rf_dst_we;
    logic [31:0] rf_base_data, rf_dst_data;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done_o, illegal_o;

    logic [31:0] regs [16];
    logic [31:0] mem  [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_rn_data = regs[rf_rn_idx];
    assign rf_rd_data = regs[rf_rd_idx];

    hsx_unit dut (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
        .nzcv(nzcv),
        .rf_rn_idx(rf_rn_idx), .rf_rn_data(rf_rn_data),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_base_we(rf_base_we), .rf_base_data(rf_base_data),
        .rf_dst_we(rf_dst_we), .rf_dst_data(rf_dst_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done_o(done_o), .illegal_o(illegal_o)
    );

    typedef struct {
        bit          illegal;
        bit          req;
        bit          we;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        bit          bwe;
        logic [31:0] bval;
        bit          dwe;
        logic [31:0] dval;
        logic [3:0]  rn;
        logic [3:0]  rd;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] c, input bit p, input bit u,
            input bit w, input bit l, input logic [3:0] rn, input logic [3:0] rd,
            input logic [1:0] sh, input logic [7:0] off);
        return {c, 3'b000, p, u, 1'b1, w, l, rn, rd, off[7:4], 1'b1, sh, 1'b1, off[3:0]};
    endfunction

    // Reference condition table, flags {N,Z,C,V}.
    function automatic bit cpass(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        bit r;
        case (c)
            0: r = z;            1: r = !z;
            2: r = cy;           3: r = !cy;
            4: r = n;            5: r = !n;
            6: r = v;            7: r = !v;
            8: r = cy && !z;     9: r = !cy || z;
            10: r = (n == v);    11: r = (n != v);
            12: r = !z && (n == v);
            13: r = z || (n != v);
            14: r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic exp_t predict(input logic [31:0] ir, input logic [3:0] f, input string tag);
        exp_t e;
        logic [31:0] base, modv, a, w, rdv;
        logic [15:0] hv;
        logic [7:0]  bv;
        e = '{default: 0};
        e.tag = tag;
        e.rn = ir[19:16];
        e.rd = ir[15:12];
        e.illegal = (ir[27:25] != 3'b000) || !ir[22] || !ir[7] || !ir[4] ||
                    (ir[6:5] == 2'b00) || (!ir[24] && ir[21]);
        e.req = !e.illegal && cpass(ir[31:28], f);
        if (!e.req) return e;
        base = regs[e.rn];
        rdv  = regs[e.rd];
        modv = ir[23] ? base + {24'd0, ir[11:8], ir[3:0]} : base - {24'd0, ir[11:8], ir[3:0]};
        a    = ir[24] ? modv : base;
        e.addr = a;
        e.we   = !ir[20];
        if (ir[5]) begin
            e.be    = a[1] ? 4'b1100 : 4'b0011;
            e.wdata = {rdv[15:0], rdv[15:0]};
        end else begin
            e.be    = 4'b0001 << a[1:0];
            e.wdata = {4{rdv[7:0]}};
        end
        w  = mem[a[5:2]];
        hv = a[1] ? w[31:16] : w[15:0];
        bv = w[a[1:0]*8 +: 8];
        if (ir[5]) e.dval = ir[6] ? {{16{hv[15]}}, hv} : {16'd0, hv};
        else       e.dval = {{24{bv[7]}}, bv};
        e.dwe  = ir[20];
        e.bval = modv;
        e.bwe  = (ir[24] ? ir[21] : 1'b1) && !(ir[20] && e.rn == e.rd);
        return e;
    endfunction

    // Driver: predict, queue the expectation, offer the word, wait for completion.
    task automatic send(input logic [31:0] ir, input logic [3:0] f, input string tag);
        q.push_back(predict(ir, f, tag));
        @(negedge clk);
        nzcv        = f;
        instr_word  = ir;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
    endtask

    // Memory responder with latency of one to three cycles.
    initial begin
        int lat_ctr = 0;
        forever begin
            @(negedge clk);
            #Q;
            if (rst_n && mem_req) begin
                logic [3:0] idx;
                idx = mem_addr[5:2];
                if (mem_we)
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[idx][b*8 +: 8] = mem_wdata[b*8 +: 8];
                repeat (1 + (lat_ctr % 3)) @(negedge clk);
                lat_ctr++;
                mem_rvalid = 1'b1;
                mem_rdata  = mem[idx];
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = '0;
            end
        end
    end

    // Monitor: record requests, pop and compare on completion.
    initial begin
        bit          saw = 1'b0;
        logic [31:0] a_addr = '0, a_wdata = '0;
        logic [3:0]  a_be = '0;
        bit          a_we = 1'b0;
        forever begin
            @(negedge clk);
            #Q;
            if (rst_n) begin
                if (mem_req) begin
                    saw = 1'b1; a_addr = mem_addr; a_be = mem_be; a_we = mem_we; a_wdata = mem_wdata;
                    chk(!instr_ready, "R1", "ready during request", {31'd0, instr_ready}, 32'd0);
                end
                if (done_o) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R10", "completion with nothing pending", 32'd1, 32'd0);
                    end else begin
                        exp_t e;
                        logic [31:0] m;
                        e = q.pop_front();
                        chk(!instr_ready, "R1", "ready at completion", {31'd0, instr_ready}, 32'd0);
                        chk(illegal_o == e.illegal, {e.tag, " R5"}, "illegal flag", {31'd0, illegal_o}, {31'd0, e.illegal});
                        chk(saw == e.req, {e.tag, " R6"}, "memory access made", {31'd0, saw}, {31'd0, e.req});
                        if (e.req && saw) begin
                            m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
                            chk(a_addr == e.addr, e.tag, "address", a_addr, e.addr);
                            chk(a_we == e.we, e.tag, "write select", {31'd0, a_we}, {31'd0, e.we});
                            chk(a_be == e.be, {e.tag, " R7"}, "byte enables", {28'd0, a_be}, {28'd0, e.be});
                            if (e.we) chk((a_wdata & m) == (e.wdata & m), {e.tag, " R7"}, "store lanes", a_wdata & m, e.wdata & m);
                        end
                        chk(rf_base_we == e.bwe, e.tag, "base write enable", {31'd0, rf_base_we}, {31'd0, e.bwe});
                        if (e.bwe) chk(rf_base_data == e.bval, e.tag, "base value", rf_base_data, e.bval);
                        chk(rf_dst_we == e.dwe, e.tag, "dest write enable", {31'd0, rf_dst_we}, {31'd0, e.dwe});
                        if (e.dwe) chk(rf_dst_data == e.dval, {e.tag, " R8"}, "load value", rf_dst_data, e.dval);
                        if (e.bwe) regs[e.rn] = e.bval;
                        if (e.dwe) regs[e.rd] = e.dval;
                    end
                    saw = 1'b0;
                end
            end
        end
    end

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            regs[i] = 32'(i * 4);
            mem[i]  = {4'hF, 4'(i), 8'h35, 4'h8, 4'(i), 8'h6A};
        end
        repeat (3) @(negedge clk);
        #Q;
        chk(instr_ready == 1'b1, "R1", "ready in reset", {31'd0, instr_ready}, 32'd1);
        chk(mem_req == 1'b0, "R1", "no request in reset", {31'd0, mem_req}, 32'd0);
        chk(done_o == 1'b0, "R1", "no completion in reset", {31'd0, done_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Pre-index up, no write-back, unsigned halfword upper lane.
        regs[1] = 32'h20;
        send(mk(4'd14, 1, 1, 0, 1, 4'd1, 4'd2, 2'b01, 8'h16), 4'h0, "R2 R3 pre up");
        // Post-index down, signed byte, always writes back.
        regs[3] = 32'h40;
        send(mk(4'd14, 0, 0, 0, 1, 4'd3, 4'd4, 2'b10, 8'h13), 4'h0, "R2 R4 post down");
        // Pre-index down with write-back, signed halfword.
        regs[5] = 32'h10;
        send(mk(4'd14, 1, 0, 1, 1, 4'd5, 4'd6, 2'b11, 8'h02), 4'h0, "R3 pre wb");
        // Signed byte from lane 1 and lane 3.
        regs[7] = 32'h21;
        send(mk(4'd14, 1, 1, 0, 1, 4'd7, 4'd8, 2'b10, 8'h00), 4'h0, "R8 sbyte lane1");
        send(mk(4'd14, 1, 1, 0, 1, 4'd7, 4'd8, 2'b10, 8'h02), 4'h0, "R8 sbyte lane3");
        // Halfword stores to both halves, then read back.
        regs[8] = 32'h32;
        regs[9] = 32'hCAFE_BEEF;
        send(mk(4'd14, 1, 1, 0, 0, 4'd8, 4'd9, 2'b01, 8'h00), 4'h0, "R7 store upper half");
        send(mk(4'd14, 1, 0, 0, 0, 4'd8, 4'd9, 2'b11, 8'h02), 4'h0, "R7 store lower half");
        send(mk(4'd14, 1, 1, 0, 1, 4'd8, 4'd10, 2'b11, 8'h00), 4'h0, "R8 read back");
        // Byte stores walking all four lanes via post-index increment.
        regs[11] = 32'h50;
        for (int k = 0; k < 4; k++) begin
            regs[12] = 32'h1234_5670 + 32'(k);
            send(mk(4'd14, 0, 1, 0, 0, 4'd11, 4'd12, 2'b10, 8'h01), 4'h0, "R7 R4 byte store lane");
        end
        send(mk(4'd14, 1, 1, 0, 1, 4'd11, 4'd13, 2'b11, 8'h9C), 4'h0, "R2 large offset");
        // All sixteen conditions under varied flags.
        for (int c = 0; c < 16; c++) begin
            send(mk(4'(c), 1, 1, 0, 1, 4'd1, 4'd14, 2'b01, 8'h04), 4'((c * 5 + 3) % 16), "R6 cond");
            send(mk(4'(c), 1, 1, 0, 1, 4'd1, 4'd14, 2'b11, 8'h04), 4'((c * 7) % 16), "R6 cond");
        end
        // Illegal encodings.
        send(mk(4'd14, 1, 1, 0, 1, 4'd1, 4'd2, 2'b00, 8'h04), 4'h0, "R5 swap code");
        send(mk(4'd14, 0, 1, 1, 1, 4'd1, 4'd2, 2'b01, 8'h04), 4'h0, "R5 post with W");
        send(mk(4'd14, 1, 1, 0, 1, 4'd1, 4'd2, 2'b01, 8'h04) & ~32'h0040_0000, 4'h0, "R5 fixed bit");
        send(mk(4'd15, 0, 1, 1, 1, 4'd1, 4'd2, 2'b01, 8'h04), 4'h0, "R5 illegal and never");
        // Load with base equal to destination.
        regs[12] = 32'h08;
        send(mk(4'd14, 0, 1, 0, 1, 4'd12, 4'd12, 2'b01, 8'h04), 4'h0, "R9 post same reg");
        regs[13] = 32'h1A;
        send(mk(4'd14, 1, 1, 1, 1, 4'd13, 4'd13, 2'b10, 8'h05), 4'h0, "R9 pre wb same reg");
        // Store with base equal to data register still writes back.
        regs[15] = 32'h24;
        send(mk(4'd14, 0, 0, 0, 0, 4'd15, 4'd15, 2'b01, 8'h10), 4'h0, "R4 store same reg");

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R10", "all items completed", 32'(q.size()), 32'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule